// File: doc/BRIEF.md
# Tri-Port Latched Bus Exchanger

The block joins one W-bit host-side port (A) with two W-bit memory-side ports (B1 and B2). The default W is 12. Four level-sensitive transparent latches store the data. Two of them carry A toward each B port, so a processor can post one word to an even bank and another to an odd bank, or the same word to both. The other two carry each B port toward A. A select line then decides which of those two inbound latches feeds port A, which supports reading interleaved banks and multiplexing addresses.

Every port is split into an input vector, an output vector and a per-bit output-enable vector. An output-enable vector of all ones means the port drives its output. All zeros means the port is high-impedance, and its output data is then a don't-care. Each port has its own active-low enable, so one B port can drive while the other acts as an input. An active-low asynchronous reset clears all four latches.

Top module: `xb_tri_exchange`

## Requirements
- R1: While rst_n is low, all four latches hold zero. After release with every latch enable low, each enabled port outputs zero.
- R2: While cap_a_to_b1 (or cap_a_to_b2) is high and the matching en_b1_n (en_b2_n) is low, b1_out (b2_out) equals a_in in the same instant, with no clock involved.
- R3: When an outbound latch enable falls, the latch keeps the a_in value present at that fall. Later changes on a_in do not show on that B output until the enable goes high again.
- R4: The two outbound latches are independent. Loading one leaves the other's content unchanged, and raising both enables loads the same a_in word into both.
- R5: While cap_b1_to_a (or cap_b2_to_a) is high, the matching inbound latch follows b1_in (b2_in). After that enable falls, the latch holds the value present at the fall.
- R6: When sel_b1 is 1, a_out shows the B1 inbound latch. When sel_b1 is 0, a_out shows the B2 inbound latch. This applies only while en_a_n is low.
- R7: When en_a_n is high, a_oe is all zeros whatever the latches hold. When en_a_n is low, a_oe is all ones.
- R8: b1_oe is all ones exactly when en_b1_n is low, and all zeros otherwise. b2_oe follows en_b2_n in the same way, independently of the B1 enable. Turning an output enable off and back on leaves the latched value unchanged.
- R9: An inbound latch captures its B input whatever that B port's output enable is set to.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Active-low asynchronous clear of all latches |
| sel_b1 | input | 1 | 1: A is fed from the B1 inbound latch; 0: from the B2 inbound latch |
| cap_a_to_b1 | input | 1 | Latch enable, A toward B1 (high = transparent) |
| cap_a_to_b2 | input | 1 | Latch enable, A toward B2 (high = transparent) |
| cap_b1_to_a | input | 1 | Latch enable, B1 toward A (high = transparent) |
| cap_b2_to_a | input | 1 | Latch enable, B2 toward A (high = transparent) |
| en_a_n | input | 1 | Active-low output enable of port A |
| en_b1_n | input | 1 | Active-low output enable of port B1 |
| en_b2_n | input | 1 | Active-low output enable of port B2 |
| a_in | input | W | Data arriving on port A |
| a_out | output | W | Data driven on port A |
| a_oe | output | W | Per-bit drive enable of port A |
| b1_in | input | W | Data arriving on port B1 |
| b1_out | output | W | Data driven on port B1 |
| b1_oe | output | W | Per-bit drive enable of port B1 |
| b2_in | input | W | Data arriving on port B2 |
| b2_out | output | W | Data driven on port B2 |
| b2_oe | output | W | Per-bit drive enable of port B2 |

## Verification
No result of this block waits on a clock. A transparent latch, the A-side selector and all three enable vectors respond in zero cycles, and a held value appears the moment its enable falls. The bench therefore changes one input, waits a short settling delay well inside a clock period, and then samples. Each hold check places the capture-enable fall and the following data change in separate time steps. That way the expected value is the data present before the fall, and no ordering within one time step can decide the result.

// File: rtl/xb_pkg.sv
// Shared types of the tri-port bus exchanger.
package xb_pkg;
    // Which inbound latch feeds port A; the encoding matches the sel_b1 pin.
    typedef enum logic {
        PICK_B2 = 1'b0,
        PICK_B1 = 1'b1
    } pick_e;
endpackage

// File: rtl/xb_latch.sv
// Level-sensitive storage of one word.
// Transparent while en is high; keeps the last value when en falls.
// Assumes rst_n is an asynchronous active-low clear.
module xb_latch #(
    parameter int W = 12
) (
    input  logic         rst_n,
    input  logic         en,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Storage: clear on reset, follow d while open, hold otherwise.
    always_latch begin
        if (!rst_n)
            q <= '0;
        else if (en)
            q <= d;
    end
endmodule

// File: rtl/xb_pick.sv
// Two-way word selector that chooses the inbound latch feeding port A.
// Assumes both inputs are stable latch outputs.
module xb_pick
    import xb_pkg::*;
#(
    parameter int W = 12
) (
    input  pick_e        which,
    input  logic [W-1:0] from_b1,
    input  logic [W-1:0] from_b2,
    output logic [W-1:0] y
);
    // Selection: route the chosen inbound word.
    always_comb begin
        unique case (which)
            PICK_B1: y = from_b1;
            default: y = from_b2;
        endcase
    end
endmodule

// File: rtl/xb_drive.sv
// Port driver: turns an active-low enable into a per-bit drive vector.
// Data is forced to zero when not driven; the value is a don't-care then.
module xb_drive #(
    parameter int W = 12
) (
    input  logic         en_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] oe
);
    // Drive: replicate the enable, gate the data.
    always_comb begin
        oe = {W{~en_n}};
        q  = en_n ? '0 : d;
    end
endmodule

// File: rtl/xb_tri_exchange.sv
// Tri-port latched bus exchanger.
// Two outbound latches carry port A toward B1 and B2. Two inbound latches
// carry B1 and B2 toward port A through a selector. Every port has its own
// active-low output enable. Inbound latches sample the B input vectors
// whatever the B output enables are set to.
module xb_tri_exchange
    import xb_pkg::*;
#(
    parameter int W = 12
) (
    input  logic         rst_n,
    input  logic         sel_b1,
    input  logic         cap_a_to_b1,
    input  logic         cap_a_to_b2,
    input  logic         cap_b1_to_a,
    input  logic         cap_b2_to_a,
    input  logic         en_a_n,
    input  logic         en_b1_n,
    input  logic         en_b2_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] a_oe,
    input  logic [W-1:0] b1_in,
    output logic [W-1:0] b1_out,
    output logic [W-1:0] b1_oe,
    input  logic [W-1:0] b2_in,
    output logic [W-1:0] b2_out,
    output logic [W-1:0] b2_oe
);
    localparam int LANES = 2;

    logic [LANES-1:0]        le_out, le_in, en_b_n;
    logic [LANES-1:0][W-1:0] out_q, in_q, in_d, b_q, b_oe;
    logic [W-1:0]            a_pick;

    // Gather per-lane controls so the lanes can be generated.
    always_comb begin
        le_out = {cap_a_to_b2, cap_a_to_b1};
        le_in  = {cap_b2_to_a, cap_b1_to_a};
        en_b_n = {en_b2_n, en_b1_n};
        in_d   = {b2_in, b1_in};
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        xb_latch #(.W(W)) u_out (
            .rst_n(rst_n), .en(le_out[g]), .d(a_in), .q(out_q[g])
        );
        xb_latch #(.W(W)) u_in (
            .rst_n(rst_n), .en(le_in[g]), .d(in_d[g]), .q(in_q[g])
        );
        xb_drive #(.W(W)) u_bdrv (
            .en_n(en_b_n[g]), .d(out_q[g]), .q(b_q[g]), .oe(b_oe[g])
        );

        // Lane checks beside the lane logic.
        always_comb begin
            if (rst_n && le_out[g]) begin
                // R2
                out_pass_chk: assert (out_q[g] == a_in);
            end
            if (rst_n && le_in[g]) begin
                // R5
                in_pass_chk: assert (in_q[g] == in_d[g]);
            end
            if (rst_n && !en_b_n[g]) begin
                // R8
                b_drive_chk: assert (b_q[g] == out_q[g] && b_oe[g] == '1);
            end
        end
    end

    xb_pick #(.W(W)) u_pick (
        .which(pick_e'(sel_b1)), .from_b1(in_q[0]), .from_b2(in_q[1]),
        .y(a_pick)
    );

    xb_drive #(.W(W)) u_adrv (
        .en_n(en_a_n), .d(a_pick), .q(a_out), .oe(a_oe)
    );

    // Port mapping of the B-side drivers.
    always_comb begin
        b1_out = b_q[0];
        b1_oe  = b_oe[0];
        b2_out = b_q[1];
        b2_oe  = b_oe[1];
    end

    // Port A checks against the inbound latches.
    always_comb begin
        if (rst_n && !en_a_n) begin
            // R6
            a_route_chk: assert (a_out == (sel_b1 ? in_q[0] : in_q[1]));
        end
        if (rst_n && en_a_n) begin
            // R7
            a_hiz_chk: assert (a_oe == '0);
        end
        if (!rst_n) begin
            // R1
            clear_chk: assert (out_q == '0 && in_q == '0);
        end
    end
endmodule

// File: tb/tb_xb_tri_exchange.sv
module tb_xb_tri_exchange;
    localparam int W = 12;
    localparam int PERIOD = 10;
    localparam int LIMIT = 100000;

    logic clk = 0;
    logic rst_n, sel_b1, cap_a_to_b1, cap_a_to_b2, cap_b1_to_a, cap_b2_to_a;
    logic en_a_n, en_b1_n, en_b2_n;
    logic [W-1:0] a_in, a_out, a_oe, b1_in, b1_out, b1_oe, b2_in, b2_out, b2_oe;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    xb_tri_exchange #(.W(W)) dut (
        .rst_n(rst_n), .sel_b1(sel_b1),
        .cap_a_to_b1(cap_a_to_b1), .cap_a_to_b2(cap_a_to_b2),
        .cap_b1_to_a(cap_b1_to_a), .cap_b2_to_a(cap_b2_to_a),
        .en_a_n(en_a_n), .en_b1_n(en_b1_n), .en_b2_n(en_b2_n),
        .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
        .b1_in(b1_in), .b1_out(b1_out), .b1_oe(b1_oe),
        .b2_in(b2_in), .b2_out(b2_out), .b2_oe(b2_oe)
    );

    always #(PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        #(PERIOD/5);
    endtask

    // R1: clear and idle outputs
    task automatic t_reset();
        rst_n = 0; settle();
        rst_n = 1; settle();
        chk("R1 b1", b1_out, '0);
        chk("R1 b2", b2_out, '0);
        sel_b1 = 1; settle(); chk("R1 a via b1", a_out, '0);
        sel_b1 = 0; settle(); chk("R1 a via b2", a_out, '0);
    endtask

    // R2 and R3: outbound pass-through and hold
    task automatic t_out_pass_hold();
        a_in = 12'h5A3; cap_a_to_b1 = 1; settle();
        chk("R2 b1 pass", b1_out, 12'h5A3);
        a_in = 12'h0F1; settle();
        chk("R2 b1 follows", b1_out, 12'h0F1);
        cap_a_to_b1 = 0; settle();
        a_in = 12'hAAA; settle();
        chk("R3 b1 hold", b1_out, 12'h0F1);
        chk("R4 b2 untouched", b2_out, '0);
        cap_a_to_b2 = 1; settle();
        chk("R2 b2 pass", b2_out, 12'hAAA);
        cap_a_to_b2 = 0; settle();
        a_in = 12'h123; settle();
        chk("R3 b2 hold", b2_out, 12'hAAA);
        chk("R4 b1 kept", b1_out, 12'h0F1);
    endtask

    // R4: load both at once
    task automatic t_out_both();
        a_in = 12'h9C6; cap_a_to_b1 = 1; cap_a_to_b2 = 1; settle();
        cap_a_to_b1 = 0; cap_a_to_b2 = 0; settle();
        a_in = 12'h000; settle();
        chk("R4 both b1", b1_out, 12'h9C6);
        chk("R4 both b2", b2_out, 12'h9C6);
    endtask

    // R5, R6: inbound latches and selector
    task automatic t_in_path();
        en_a_n = 0;
        b1_in = 12'h3E7; b2_in = 12'h6B2;
        cap_b1_to_a = 1; cap_b2_to_a = 1; settle();
        sel_b1 = 1; settle(); chk("R5 b1 pass", a_out, 12'h3E7);
        sel_b1 = 0; settle(); chk("R5 b2 pass", a_out, 12'h6B2);
        cap_b1_to_a = 0; cap_b2_to_a = 0; settle();
        b1_in = 12'h111; b2_in = 12'h222; settle();
        sel_b1 = 1; settle(); chk("R6 sel1 held", a_out, 12'h3E7);
        sel_b1 = 0; settle(); chk("R6 sel0 held", a_out, 12'h6B2);
        cap_b1_to_a = 1; settle(); cap_b1_to_a = 0; settle();
        chk("R6 b2 not changed by b1 load", a_out, 12'h6B2);
        sel_b1 = 1; settle(); chk("R5 b1 reload", a_out, 12'h111);
    endtask

    // R7: port A enable
    task automatic t_a_enable();
        chk("R7 a_oe on", a_oe, '1);
        en_a_n = 1; settle();
        chk("R7 a_oe off", a_oe, '0);
        cap_b1_to_a = 1; b1_in = 12'hFED; settle();
        chk("R7 a_oe off while open", a_oe, '0);
        cap_b1_to_a = 0; settle();
        en_a_n = 0; settle();
        chk("R7 a after reenable", a_out, 12'hFED);
    endtask

    // R8, R9: independent B enables, read one while writing the other
    task automatic t_b_enables();
        en_b1_n = 1; en_b2_n = 0; settle();
        chk("R8 b1_oe off", b1_oe, '0);
        chk("R8 b2_oe on", b2_oe, '1);
        b1_in = 12'h4C4; cap_b1_to_a = 1; a_in = 12'h7A7; cap_a_to_b2 = 1; settle();
        cap_b1_to_a = 0; cap_a_to_b2 = 0; settle();
        sel_b1 = 1; settle();
        chk("R9 b1 read while disabled", a_out, 12'h4C4);
        chk("R8 b2 written", b2_out, 12'h7A7);
        en_b2_n = 1; settle();
        chk("R8 b2_oe off", b2_oe, '0);
        chk("R8 b1_oe still off", b1_oe, '0);
        b2_in = 12'h5D5; cap_b2_to_a = 1; settle(); cap_b2_to_a = 0; settle();
        sel_b1 = 0; settle();
        chk("R9 b2 read while disabled", a_out, 12'h5D5);
        en_b1_n = 0; en_b2_n = 0; settle();
        chk("R8 b1 content kept", b1_out, 12'h9C6);
        chk("R8 b2 content kept", b2_out, 12'h7A7);
        chk("R8 b1_oe on", b1_oe, '1);
    endtask

    // R1: reset clears stored words
    task automatic t_reset_again();
        rst_n = 0; settle(); rst_n = 1; settle();
        chk("R1 b1 cleared", b1_out, '0);
        chk("R1 b2 cleared", b2_out, '0);
        chk("R1 a cleared", a_out, '0);
    endtask

    initial begin
        rst_n = 0; sel_b1 = 0;
        cap_a_to_b1 = 0; cap_a_to_b2 = 0; cap_b1_to_a = 0; cap_b2_to_a = 0;
        en_a_n = 0; en_b1_n = 0; en_b2_n = 0;
        a_in = '0; b1_in = '0; b2_in = '0;
        #(PERIOD*2);
        t_reset();
        t_out_pass_hold();
        t_out_both();
        t_in_path();
        t_a_enable();
        t_b_enables();
        t_reset_again();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == LIMIT) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%0d exp=<%0d", cycles, LIMIT);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule